// File: doc/BRIEF.md
# Sign-Sign LMS Equalizer Tap Adapter

This block adjusts the coefficient set of a decision-based equalizer and, alongside it, an estimate of the ideal signed symbol amplitude. It updates from the symbol stream alone. For every accepted symbol it uses three inputs: the sampled value at the slicer input, the binary decision for that sample, and a short record of earlier decisions that the block keeps itself. From these it works out whether the sample lies above or below the expected amplitude for that decision. Each coefficient then takes a vote: up if the polarity of that deviation agrees with the polarity of the matching past decision, down if not. The amplitude estimate votes the same way against the current decision, so it follows the real signal level and needs no value known in advance.

Votes are summed over a window of 2^M accepted symbols, where M is chosen at run time. At the end of each window every register moves by one fixed step toward the sign of its sum. Registers never wrap past their limits. The coefficient and amplitude registers are plain outputs and can drive a receive feedback equalizer or be sent to a far-end transmit filter by other logic. Software can seed them through a load port and can stop adaptation with an enable input.

Top module: `lms_ss_adapter`

## Requirements
- R1: After reset every coefficient output and the amplitude output are zero, and all stored past decisions read as -1.
- R2: Decisions use 1 for +1 and 0 for -1. The deviation is the sample minus the amplitude times the current decision, computed with no overflow. A deviation of exactly zero counts as non-negative.
- R3: The amplitude vote is +1 when the sign of the deviation equals the current decision, and -1 otherwise.
- R4: Coefficient n (n = 1..NTAPS, bits [n*W-1:(n-1)*W] of the coefficient bus) votes +1 when the sign of the deviation equals the decision taken n accepted symbols earlier, and -1 otherwise. Every accepted symbol shifts the current decision into the history, even while adaptation is disabled.
- R5: A register that is asked to move beyond -2^(W-1) or 2^(W-1)-1 stays at that limit.
- R6: With a window exponent of M, votes are summed over 2^M enabled symbols. On the clock edge that takes the last symbol of the window, each register moves by STEP toward the sign of its sum, or holds if the sum is zero. Between window ends the outputs do not change.
- R7: While adaptation is disabled, accepted symbols add no votes, the window does not advance and all outputs hold.
- R8: Load has priority over everything else. On the next edge it writes the coefficient and amplitude values given at the load port, and it discards any partial votes and window progress.
- R9: Cycles without an accepted symbol change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Adaptation enable |
| sym_valid_i | input | 1 | A symbol is presented this cycle |
| sample_i | input | SW | Signed sample at the slicer input |
| dec_i | input | 1 | Decision for this sample (1 = +1, 0 = -1) |
| win_exp_i | input | MW | Window exponent M |
| load_i | input | 1 | Write the initial values |
| load_taps_i | input | NTAPS*W | Coefficients to load, coefficient 1 in the low bits |
| load_lvl_i | input | W | Amplitude to load |
| taps_o | output | NTAPS*W | Signed coefficients, coefficient 1 in the low bits |
| lvl_o | output | W | Signed amplitude estimate |

## Verification
The bench uses the default build: four coefficients, 8-bit samples and registers, a step of one and a 3-bit window exponent. With 8-bit registers, loaded values sit only a step or two from the limits, so clamping at both ends can be reached in a handful of symbols. The short window exponent allows both per-symbol operation and four-symbol windows, including a window whose votes sum to zero. A small reference model in the bench tracks the decision history, which is what separates one coefficient's vote from the next.

// File: rtl/lms_ss_pkg.sv
`timescale 1ns/1ps
package lms_ss_pkg;

   // Direction a register takes at the end of a voting window
   typedef enum logic [1:0] {
      DIR_HOLD = 2'd0,
      DIR_UP   = 2'd1,
      DIR_DOWN = 2'd2
   } step_dir_e;

   function automatic int unsigned max_int(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lms_err_sign.sv
`timescale 1ns/1ps
// Sign of (sample - level * decision); zero counts as non-negative.
module lms_err_sign #(
   parameter int unsigned SW = 8,
   parameter int unsigned W  = 8
) (
   input  logic [SW-1:0] sample_i,
   input  logic [W-1:0]  lvl_i,
   input  logic          dec_i,
   output logic          nonneg_o
);
   localparam int unsigned EW = lms_ss_pkg::max_int(SW, W) + 2;

   logic signed [EW-1:0] smp_x;
   logic signed [EW-1:0] lvl_x;
   logic signed [EW-1:0] dev;

   always_comb begin
      smp_x = EW'($signed(sample_i));
      lvl_x = EW'($signed(lvl_i));
      dev   = dec_i ? (smp_x - lvl_x) : (smp_x + lvl_x);
      nonneg_o = ~dev[EW-1];
   end
endmodule

// File: rtl/lms_window.sv
`timescale 1ns/1ps
// Counts enabled symbols and flags the last one of a 2^M window.
module lms_window #(
   parameter int unsigned MW = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          adv_i,
   input  logic [MW-1:0] exp_i,
   output logic          last_o
);
   localparam int unsigned CW = (1 << MW) - 1;

   logic [CW-1:0] cnt_q;
   logic [CW:0]   span_w;
   logic [CW-1:0] mask;

   always_comb begin
      span_w = ((CW+1)'(1) << exp_i) - (CW+1)'(1);
      mask   = span_w[CW-1:0];
      last_o = adv_i && (cnt_q >= mask);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (last_o)  cnt_q <= '0;
      else if (adv_i)   cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/lms_vote_lane.sv
`timescale 1ns/1ps
// Sums +/-1 votes; at window end reports the sign of the sum.
module lms_vote_lane #(
   parameter int unsigned ACC_W = 9
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  clr_i,
   input  logic                  vote_en_i,
   input  logic                  up_i,
   input  logic                  last_i,
   output lms_ss_pkg::step_dir_e dir_o
);
   import lms_ss_pkg::*;

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] acc_nxt;

   always_comb begin
      acc_nxt = up_i ? (acc_q + ACC_W'(1)) : (acc_q - ACC_W'(1));
      dir_o   = DIR_HOLD;
      if (vote_en_i && last_i) begin
         if (acc_nxt > 0)      dir_o = DIR_UP;
         else if (acc_nxt < 0) dir_o = DIR_DOWN;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   acc_q <= '0;
      else if (clr_i)                acc_q <= '0;
      else if (vote_en_i && last_i)  acc_q <= '0;
      else if (vote_en_i)            acc_q <= acc_nxt;
   end
endmodule

// File: rtl/lms_sat_reg.sv
`timescale 1ns/1ps
// Signed register that steps by STEP and clamps at its limits.
module lms_sat_reg #(
   parameter int unsigned W    = 8,
   parameter int unsigned STEP = 1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  load_i,
   input  logic [W-1:0]          load_val_i,
   input  lms_ss_pkg::step_dir_e dir_i,
   output logic [W-1:0]          q_o
);
   import lms_ss_pkg::*;

   localparam logic signed [W:0] HI = (W+1)'((1 << (W-1)) - 1);
   localparam logic signed [W:0] LO = -(W+1)'(1 << (W-1));
   localparam logic signed [W:0] ST = (W+1)'(STEP);

   logic signed [W:0] cur_x;
   logic signed [W:0] nxt_x;

   always_comb begin
      cur_x = (W+1)'($signed(q_o));
      nxt_x = cur_x;
      unique case (dir_i)
         DIR_UP:   nxt_x = (cur_x > HI - ST) ? HI : cur_x + ST;
         DIR_DOWN: nxt_x = (cur_x < LO + ST) ? LO : cur_x - ST;
         default:  nxt_x = cur_x;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o <= '0;
      else if (load_i) q_o <= load_val_i;
      else             q_o <= nxt_x[W-1:0];
   end
endmodule

// File: rtl/lms_ss_adapter.sv
`timescale 1ns/1ps
module lms_ss_adapter #(
   parameter int unsigned NTAPS = 4,
   parameter int unsigned W     = 8,
   parameter int unsigned SW    = 8,
   parameter int unsigned STEP  = 1,
   parameter int unsigned MW    = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic               sym_valid_i,
   input  logic [SW-1:0]      sample_i,
   input  logic               dec_i,
   input  logic [MW-1:0]      win_exp_i,
   input  logic               load_i,
   input  logic [NTAPS*W-1:0] load_taps_i,
   input  logic [W-1:0]       load_lvl_i,
   output logic [NTAPS*W-1:0] taps_o,
   output logic [W-1:0]       lvl_o
);
   import lms_ss_pkg::*;

   localparam int unsigned NL    = NTAPS + 1;
   localparam int unsigned CW    = (1 << MW) - 1;
   localparam int unsigned ACC_W = CW + 2;

   // elaboration-time parameter checks
   if (NTAPS < 1) begin : g_bad_ntaps
      initial $fatal(1, "NTAPS must be at least 1");
   end
   if (W < 2) begin : g_bad_w
      initial $fatal(1, "W must be at least 2");
   end
   if (SW < 2) begin : g_bad_sw
      initial $fatal(1, "SW must be at least 2");
   end
   if (STEP < 1 || STEP >= (1 << (W-1))) begin : g_bad_step
      initial $fatal(1, "STEP must lie in 1 .. 2^(W-1)-1");
   end
   if (MW < 1 || MW > 4) begin : g_bad_mw
      initial $fatal(1, "MW must lie in 1 .. 4");
   end

   logic              vote_en;
   logic              win_last;
   logic              e_nonneg;
   logic [NTAPS-1:0]  hist_q;      // hist_q[n-1] holds the decision n symbols back
   logic [NL-1:0]     up;
   step_dir_e         dir [NL];

   assign vote_en = sym_valid_i & en_i & ~load_i;

   // decision history, shifted on every accepted symbol
   if (NTAPS == 1) begin : g_hist_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)          hist_q <= '0;
         else if (sym_valid_i) hist_q <= dec_i;
      end
   end else begin : g_hist_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)          hist_q <= '0;
         else if (sym_valid_i) hist_q <= {hist_q[NTAPS-2:0], dec_i};
      end
   end

   lms_err_sign #(.SW(SW), .W(W)) u_err (
      .sample_i (sample_i),
      .lvl_i    (lvl_o),
      .dec_i    (dec_i),
      .nonneg_o (e_nonneg)
   );

   lms_window #(.MW(MW)) u_win (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (load_i),
      .adv_i  (vote_en),
      .exp_i  (win_exp_i),
      .last_o (win_last)
   );

   // lane 0 is the amplitude, lanes 1..NTAPS the coefficients
   for (genvar i = 0; i < NL; i++) begin : g_lane
      if (i == 0) begin : g_lvl
         assign up[i] = (e_nonneg == dec_i);
         lms_sat_reg #(.W(W), .STEP(STEP)) u_reg (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .load_i     (load_i),
            .load_val_i (load_lvl_i),
            .dir_i      (dir[i]),
            .q_o        (lvl_o)
         );
      end else begin : g_tap
         assign up[i] = (e_nonneg == hist_q[i-1]);
         lms_sat_reg #(.W(W), .STEP(STEP)) u_reg (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .load_i     (load_i),
            .load_val_i (load_taps_i[(i-1)*W +: W]),
            .dir_i      (dir[i]),
            .q_o        (taps_o[(i-1)*W +: W])
         );
      end

      lms_vote_lane #(.ACC_W(ACC_W)) u_vote (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .clr_i     (load_i),
         .vote_en_i (vote_en),
         .up_i      (up[i]),
         .last_i    (win_last),
         .dir_o     (dir[i])
      );
   end
endmodule

// File: rtl/lms_ss_adapter_chk.sv
`timescale 1ns/1ps
module lms_ss_adapter_chk #(
   parameter int unsigned NTAPS = 4,
   parameter int unsigned W     = 8,
   parameter int unsigned SW    = 8,
   parameter int unsigned STEP  = 1,
   parameter int unsigned MW    = 3
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               en_i,
   input logic               sym_valid_i,
   input logic [SW-1:0]      sample_i,
   input logic               dec_i,
   input logic [MW-1:0]      win_exp_i,
   input logic               load_i,
   input logic [NTAPS*W-1:0] load_taps_i,
   input logic [W-1:0]       load_lvl_i,
   input logic [NTAPS*W-1:0] taps_o,
   input logic [W-1:0]       lvl_o
);
   localparam logic signed [W+1:0] STP = (W+2)'(STEP);

   AST_LOAD_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (taps_o == $past(load_taps_i)) && (lvl_o == $past(load_lvl_i))); // R8

   AST_FROZEN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !en_i) |=> $stable(taps_o) && $stable(lvl_o)); // R7

   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !sym_valid_i) |=> $stable(taps_o) && $stable(lvl_o)); // R9

   logic signed [W+1:0] lane_x [NTAPS+1];
   assign lane_x[0] = (W+2)'($signed(lvl_o));
   for (genvar i = 1; i <= NTAPS; i++) begin : g_x
      assign lane_x[i] = (W+2)'($signed(taps_o[(i-1)*W +: W]));
   end

   for (genvar i = 0; i <= NTAPS; i++) begin : g_step
      AST_ONE_STEP_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !load_i |=> ((lane_x[i] - $past(lane_x[i])) <= STP) &&
                     ((lane_x[i] - $past(lane_x[i])) >= -STP)); // R5
   end
endmodule

bind lms_ss_adapter lms_ss_adapter_chk #(
   .NTAPS(NTAPS), .W(W), .SW(SW), .STEP(STEP), .MW(MW)
) u_chk (.*);

// File: tb/tb_lms_ss_adapter.sv
`timescale 1ns/1ps
module tb_lms_ss_adapter;
   localparam int NTAPS = 4;
   localparam int W     = 8;
   localparam int SW    = 8;
   localparam int STEP  = 1;
   localparam int MW    = 3;
   localparam int HI    = 127;
   localparam int LO    = -128;

   // stimulus table (M = 0, level starts at 0) with hand-computed level
   localparam int NV = 8;
   localparam int TB_Y   [NV] = '{20, -20, 1, 1, -2, 10, -5, 30};
   localparam bit TB_D   [NV] = '{1, 0, 1, 1, 0, 0, 1, 1};
   localparam int TB_LVL [NV] = '{1, 2, 1, 2, 1, 0, -1, 0};

   logic               clk = 0;
   logic               rst_n = 0;
   logic               en = 0;
   logic               valid = 0;
   logic [SW-1:0]      sample = '0;
   logic               dec = 0;
   logic [MW-1:0]      wexp = '0;
   logic               load = 0;
   logic [NTAPS*W-1:0] ld_taps = '0;
   logic [W-1:0]       ld_lvl = '0;
   logic [NTAPS*W-1:0] taps;
   logic [W-1:0]       lvl;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   // reference model state
   int m_tap [NTAPS];
   int m_lvl;
   int m_acc [NTAPS+1];
   int m_cnt;
   bit m_hist [NTAPS];

   always #4 clk = ~clk;   // 125 MHz

   lms_ss_adapter #(.NTAPS(NTAPS), .W(W), .SW(SW), .STEP(STEP), .MW(MW)) dut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sym_valid_i(valid),
      .sample_i(sample), .dec_i(dec), .win_exp_i(wexp), .load_i(load),
      .load_taps_i(ld_taps), .load_lvl_i(ld_lvl), .taps_o(taps), .lvl_o(lvl)
   );

   function automatic int tap_out(input int n);
      return int'($signed(taps[n*W +: W]));
   endfunction

   function automatic int clampv(input int v);
      return (v > HI) ? HI : ((v < LO) ? LO : v);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_model(input string req);
      for (int n = 0; n < NTAPS; n++) chk(req, tap_out(n), m_tap[n]);
      chk(req, int'($signed(lvl)), m_lvl);
   endtask

   task automatic model_reset();
      for (int n = 0; n < NTAPS; n++) begin m_tap[n] = 0; m_hist[n] = 0; end
      for (int n = 0; n <= NTAPS; n++) m_acc[n] = 0;
      m_lvl = 0; m_cnt = 0;
   endtask

   task automatic model_sym(input int y, input bit d);
      int e; bit enn; int v;
      if (en) begin
         e   = d ? (y - m_lvl) : (y + m_lvl);
         enn = (e >= 0);
         m_acc[0] += (enn == d) ? 1 : -1;
         for (int n = 0; n < NTAPS; n++) m_acc[n+1] += (enn == m_hist[n]) ? 1 : -1;
         if (m_cnt >= (1 << wexp) - 1) begin
            v = (m_acc[0] > 0) ? STEP : ((m_acc[0] < 0) ? -STEP : 0);
            m_lvl = clampv(m_lvl + v);
            for (int n = 0; n < NTAPS; n++) begin
               v = (m_acc[n+1] > 0) ? STEP : ((m_acc[n+1] < 0) ? -STEP : 0);
               m_tap[n] = clampv(m_tap[n] + v);
            end
            for (int n = 0; n <= NTAPS; n++) m_acc[n] = 0;
            m_cnt = 0;
         end else m_cnt++;
      end
      for (int n = NTAPS-1; n > 0; n--) m_hist[n] = m_hist[n-1];
      m_hist[0] = d;
   endtask

   task automatic sym(input int y, input bit d);
      @(negedge clk);
      sample = y[SW-1:0]; dec = d; valid = 1;
      @(negedge clk);
      valid = 0;
      model_sym(y, d);
   endtask

   task automatic do_load(input int t0, input int t1, input int t2, input int t3, input int l);
      @(negedge clk);
      ld_taps = {t3[W-1:0], t2[W-1:0], t1[W-1:0], t0[W-1:0]};
      ld_lvl = l[W-1:0]; load = 1;
      @(negedge clk);
      load = 0;
      m_tap[0] = t0; m_tap[1] = t1; m_tap[2] = t2; m_tap[3] = t3; m_lvl = l;
      for (int n = 0; n <= NTAPS; n++) m_acc[n] = 0;
      m_cnt = 0;
   endtask

   initial begin
      #(8 * 100000);
      if (!finished) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      int hold_l; int hold_t0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk_model("R1 reset state");

      // table walk, per-symbol updates
      en = 1; wexp = 0;
      for (int i = 0; i < NV; i++) begin
         sym(TB_Y[i], TB_D[i]);
         chk("R3 R2 level step", int'($signed(lvl)), TB_LVL[i]);
         chk_model("R4 coefficient votes");
      end
      // first symbol after reset: history all -1, deviation positive -> taps fell
      // (covered by model above); explicit history-dependent pattern
      sym(40, 1); sym(40, 0); sym(40, 1); sym(40, 1);
      chk_model("R4 history ordering");

      // windowed updates, M = 2
      do_load(0, 0, 0, 0, 0);
      chk_model("R8 load values");
      wexp = 2;
      sym(5, 1); sym(5, 0); sym(5, 1);
      chk("R6 mid-window hold", int'($signed(lvl)), 0);
      sym(5, 0);
      chk("R6 zero vote sum holds", int'($signed(lvl)), 0);
      chk_model("R6 window end");
      sym(50, 1); sym(50, 1); sym(50, 1);
      chk("R6 no change before window end", int'($signed(lvl)), 0);
      sym(50, 1);
      chk("R6 step at window end", int'($signed(lvl)), 1);
      chk_model("R6 window end taps");

      // load discards partial window
      sym(50, 1); sym(50, 1);
      do_load(10, -20, 30, -40, 5);
      chk_model("R8 load mid-window");
      sym(50, 1); sym(50, 1); sym(50, 1);
      chk("R8 window restarted", int'($signed(lvl)), 5);
      sym(50, 1);
      chk_model("R8 window after load");

      // adaptation disabled
      wexp = 0; en = 0;
      hold_l = int'($signed(lvl)); hold_t0 = tap_out(0);
      sym(100, 1); sym(-100, 0); sym(100, 0);
      chk("R7 level frozen", int'($signed(lvl)), hold_l);
      chk("R7 coefficient frozen", tap_out(0), hold_t0);
      en = 1;
      sym(20, 1);
      chk_model("R7 history still shifted");

      // idle cycles
      repeat (5) @(negedge clk);
      chk_model("R9 idle holds");

      // saturation high
      do_load(127, 127, 127, 127, 127);
      for (int i = 0; i < 6; i++) sym(127, 1);
      chk("R5 level clamps high", int'($signed(lvl)), HI);
      chk("R5 coefficient clamps high", tap_out(3), HI);
      chk_model("R5 high");

      // saturation low
      do_load(-128, -128, -127, -128, 0);
      for (int i = 0; i < 6; i++) sym(-50, 1);
      chk("R5 coefficient clamps low", tap_out(0), LO);
      chk("R5 coefficient reaches low", tap_out(2), LO);
      chk_model("R5 low");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule